// File: doc/BRIEF.md
# Serial Status-Read Slave Front End

This block is the serial slave front end of an on-chip nonvolatile memory. A host selects the block by pulling the active-low select line low, then shifts an 8-bit command on the serial input. When the command is the status-read code, the block streams the memory's 8-bit status word back on the serial output. It sends the word again and again until the host releases the select line. Any other command is handed to the neighbouring command logic as a one-cycle strobe that carries the command byte. While the memory runs an internal program cycle, those other commands are refused.

The serial pins are oversampled by the block's own clock, so the serial clock must be much slower than that clock. The status word carries the live busy flag in bit 0 and the memory's lower status bits above it. The top four bits are zero. During a busy period, every bit except bit 0 shows the value held when the busy period began. The serial output is presented as a data bit plus an output enable, and the pad cell combines the two into a three-state driver.

Top module: `spi_stat_if`

## Requirements
- R1: After reset, with the select line high, `soOe` is 0 and `cmdStrobe` is 0.
- R2: Command bits are taken from `si` on rising edges of `sck`, most significant bit first. The byte 0x05 starts the status stream.
- R3: The status byte is {4'b0000, status bits 3..1, busy in bit 0}. It is sent most significant bit first. `so` changes only after falling edges of `sck`, and the first bit follows the falling edge after the eighth command bit.
- R4: While the select line stays low, the status byte is sent repeatedly, with no gap, one bit per `sck` cycle.
- R5: `soOe` is 0 while the select line is high and while the command byte is being received.
- R6: During the status stream, `si` has no effect on `so` and raises no strobe.
- R7: When not busy, any command byte other than 0x05 gives exactly one `clk` cycle of `cmdStrobe`, with `cmdCode` equal to that byte. `soOe` then stays 0 until the select line rises.
- R8: While `busy` is 1, a command other than 0x05 gives no strobe.
- R9: While busy, status bits 3..1 keep the values they had in the last cycle before `busy` rose. Bit 0 follows `busy`.
- R10: Each status byte is captured when its first bit is loaded. Input changes made during a byte appear only in the next byte.
- R11: Raising the select line partway through a byte returns the block to command receive with its bit count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid when `soOe` is 1 |
| soOe | output | 1 | Output enable for the `so` pad |
| busy | input | 1 | Memory internal program cycle in progress (clk domain) |
| statusBits | input | STAT_W | Memory lower status bits, placed at bits 3..1 |
| cmdStrobe | output | 1 | One-cycle pulse for an accepted non-status command |
| cmdCode | output | DATA_W | Command byte, valid with `cmdStrobe` |

## Verification
The bench targets the points where a careless design slips. It checks that the busy freeze uses the value from before `busy` rose: a design that samples one cycle late shows the new bits. It changes inputs in the middle of a byte: a design that reads status live instead of from a snapshot corrupts the current byte. It drops the select line after half a command: a design that keeps its bit count then misframes the next read. It also sends a refused command while busy, a command that differs from 0x05 only in its top bit (which catches a reversed bit order), and a stream with `si` toggling throughout, which would disturb the output or raise a stray strobe if `si` were not ignored.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  typedef enum logic [1:0] {
    ST_RX     = 2'd0,
    ST_STREAM = 2'd1,
    ST_DROP   = 2'd2
  } stat_state_t;

  typedef struct packed {
    logic shiftIn;
    logic loadOut;
    logic shiftOut;
  } dp_ctrl_t;

endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sckIn,
  input  logic     csNIn,
  input  logic     siIn,
  input  logic     busy,
  input  logic     isStatusOp,
  output dp_ctrl_t ctl,
  output logic     siBit,
  output logic     soOe,
  output logic     cmdStrobe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSy, csSy, siSy;
  logic sckPrev;
  logic csAct, sckNow, rise, fall, lastBit;
  logic [CNT_W-1:0] bitCnt;
  stat_state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSy   <= '0;
      csSy    <= '1;
      siSy    <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSy   <= {sckSy[SYNC_STAGES-2:0], sckIn};
      csSy    <= {csSy[SYNC_STAGES-2:0], csNIn};
      siSy    <= {siSy[SYNC_STAGES-2:0], siIn};
      sckPrev <= sckSy[SYNC_STAGES-1];
    end
  end

  assign sckNow  = sckSy[SYNC_STAGES-1];
  assign siBit   = siSy[SYNC_STAGES-1];
  assign csAct   = ~csSy[SYNC_STAGES-1];
  assign rise    = csAct & sckNow & ~sckPrev;
  assign fall    = csAct & ~sckNow & sckPrev;
  assign lastBit = (bitCnt == LAST);

  always_comb begin
    ctl.shiftIn  = (state == ST_RX) & rise;
    ctl.loadOut  = (state == ST_STREAM) & fall & (bitCnt == '0);
    ctl.shiftOut = (state == ST_STREAM) & fall & (bitCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RX;
      bitCnt    <= '0;
      soOe      <= 1'b0;
      cmdStrobe <= 1'b0;
    end else if (!csAct) begin
      state     <= ST_RX;
      bitCnt    <= '0;
      soOe      <= 1'b0;
      cmdStrobe <= 1'b0;
    end else begin
      cmdStrobe <= 1'b0;
      case (state)
        ST_RX: begin
          if (rise) begin
            if (lastBit) begin
              bitCnt <= '0;
              if (isStatusOp) begin
                state <= ST_STREAM;
              end else begin
                state     <= ST_DROP;
                cmdStrobe <= ~busy;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_STREAM: begin
          if (fall) begin
            soOe   <= 1'b1;
            bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
          end
        end
        default: begin
          state <= ST_DROP;
        end
      endcase
    end
  end

  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> !soOe);

  assert_oe_stream_R4: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> (state == ST_STREAM));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> (bitCnt == '0 && state == ST_RX));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> !$past(busy));

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          STAT_W     = 3,
  parameter logic [DATA_W-1:0] OPC_STATUS = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic              siBit,
  input  logic              busy,
  input  logic [STAT_W-1:0] statusBits,
  output logic              isStatusOp,
  output logic [DATA_W-1:0] cmdCode,
  output logic              soBit
);

  logic [DATA_W-1:0] opShift, outShift, statusWord, nextOp;
  logic [STAT_W-1:0] frozen, heldBits;

  assign nextOp     = {opShift[DATA_W-2:0], siBit};
  assign isStatusOp = (nextOp == OPC_STATUS);
  assign cmdCode    = opShift;
  assign soBit      = outShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opShift <= '0;
    end else if (ctl.shiftIn) begin
      opShift <= nextOp;
    end
  end

  // Capture live bits each cycle the memory is idle; hold while busy.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozen <= '0;
    end else if (!busy) begin
      frozen <= statusBits;
    end
  end

  assign heldBits = busy ? frozen : statusBits;

  always_comb begin
    statusWord           = '0;
    statusWord[STAT_W:0] = {heldBits, busy};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
    end else if (ctl.loadOut) begin
      outShift <= statusWord;
    end else if (ctl.shiftOut) begin
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  assert_top_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadOut |=> (outShift[DATA_W-1:STAT_W+1] == '0));

  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.shiftIn, ctl.loadOut, ctl.shiftOut}) <= 1);

endmodule

// File: rtl/spi_stat_if.sv
module spi_stat_if
  import spi_stat_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          STAT_W      = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OPC_STATUS = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  output logic              so,
  output logic              soOe,
  input  logic              busy,
  input  logic [STAT_W-1:0] statusBits,
  output logic              cmdStrobe,
  output logic [DATA_W-1:0] cmdCode
);

  dp_ctrl_t ctl;
  logic siBit, isStatusOp;

  spi_stat_ctrl #(
    .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sckIn(sck),
    .csNIn(csN),
    .siIn(si),
    .busy(busy),
    .isStatusOp(isStatusOp),
    .ctl(ctl),
    .siBit(siBit),
    .soOe(soOe),
    .cmdStrobe(cmdStrobe)
  );

  spi_stat_dp #(
    .DATA_W(DATA_W),
    .STAT_W(STAT_W),
    .OPC_STATUS(OPC_STATUS)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .siBit(siBit),
    .busy(busy),
    .statusBits(statusBits),
    .isStatusOp(isStatusOp),
    .cmdCode(cmdCode),
    .soBit(so)
  );

endmodule

// File: tb/spi_stat_if_bench.sv
module spi_stat_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rstN, sck, csN, si, busy;
  logic [2:0] statusBits;
  logic so, soOe, cmdStrobe;
  logic [7:0] cmdCode;

  int checks = 0;
  int errors = 0;
  int strobeCnt = 0;
  logic [7:0] lastCode = '0;
  logic [2:0] frozenM = '0;
  logic [7:0] expQ[$];
  bit capOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_stat_if u_spi_stat_if (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si),
    .so(so), .soOe(soOe), .busy(busy), .statusBits(statusBits),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmdStrobe) begin
      strobeCnt++;
      lastCode = cmdCode;
    end
  end

  // Monitor: collect one byte from so per 8 sck rises, compare with queue.
  initial begin
    logic [7:0] got;
    int n;
    n = 0;
    got = '0;
    forever begin
      @(posedge sck);
      if (capOn) begin
        check(soOe == 1'b1, "R3 oe during stream", soOe, 1);
        got = {got[6:0], so};
        n++;
        if (n == 8) begin
          n = 0;
          if (expQ.size() == 0) check(1'b0, "R4 unexpected byte", got, 0);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(got == e, "R3/R4/R9/R10 status byte", got, e);
          end
        end
      end else n = 0;
    end
  end

  function automatic logic [7:0] expStatus();
    return {4'b0000, (busy ? frozenM : statusBits), busy};
  endfunction

  task automatic setMem(input logic b, input logic [2:0] s);
    if (!busy) frozenM = statusBits;
    busy = b;
    statusBits = s;
  endtask

  task automatic pulse(input logic b);
    si = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic selectOn();
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic selectOff();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic sendOp(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) begin
      check(soOe == 1'b0, "R5 oe during opcode", soOe, 0);
      pulse(op[i]);
    end
  endtask

  task automatic streamByte(input logic [7:0] exp, input bit chg, input logic nb, input logic [2:0] ns);
    expQ.push_back(exp);
    capOn = 1'b1;
    for (int k = 0; k < 8; k++) begin
      si = ~si;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (chg && k == 3) setMem(nb, ns);
      sck = 1'b0;
    end
    capOn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sc;
    rstN = 1'b0; sck = 1'b0; csN = 1'b1; si = 1'b0;
    busy = 1'b0; statusBits = 3'b101;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(soOe == 1'b0, "R1 oe after reset", soOe, 0);
    check(cmdStrobe == 1'b0, "R1 strobe after reset", cmdStrobe, 0);

    // R2 R3 R4 R6: plain status read, three repeats, si toggling
    sc = strobeCnt;
    selectOn();
    sendOp(8'h05);
    for (int b = 0; b < 3; b++) streamByte(expStatus(), 1'b0, 1'b0, 3'b0);
    check(strobeCnt == sc, "R6 no strobe from si during stream", strobeCnt, sc);
    selectOff();
    check(soOe == 1'b0, "R5 oe after select high", soOe, 0);
    check(expQ.size() == 0, "R4 all bytes seen", expQ.size(), 0);

    // R7 other opcode while idle
    sc = strobeCnt;
    selectOn();
    sendOp(8'h03);
    repeat (HALF) @(negedge clk);
    check(strobeCnt == sc + 1, "R7 single strobe", strobeCnt, sc + 1);
    check(lastCode == 8'h03, "R7 code", lastCode, 8'h03);
    for (int k = 0; k < 8; k++) pulse(1'b1);
    check(soOe == 1'b0, "R7 no output after other opcode", soOe, 0);
    selectOff();

    // R2 bit order: 0x85 differs from 0x05 only in the MSB
    sc = strobeCnt;
    selectOn();
    sendOp(8'h85);
    repeat (HALF) @(negedge clk);
    check(strobeCnt == sc + 1 && lastCode == 8'h85, "R2 msb first decode", lastCode, 8'h85);
    selectOff();

    // R8 busy refuses other opcode; R9 freeze
    setMem(1'b1, 3'b010);
    repeat (4) @(negedge clk);
    sc = strobeCnt;
    selectOn();
    sendOp(8'h06);
    repeat (2*HALF) @(negedge clk);
    check(strobeCnt == sc, "R8 no strobe while busy", strobeCnt, sc);
    selectOff();

    selectOn();
    sendOp(8'h05);
    check(expStatus() == 8'h0B, "R9 model frozen value", expStatus(), 8'h0B);
    streamByte(expStatus(), 1'b0, 1'b0, 3'b0);
    // R10: change mid-byte, current byte keeps snapshot
    streamByte(expStatus(), 1'b1, 1'b0, 3'b010);
    streamByte(expStatus(), 1'b0, 1'b0, 3'b0);
    selectOff();
    check(expQ.size() == 0, "R10 bytes seen", expQ.size(), 0);

    // R11 abort mid opcode then a clean read
    setMem(1'b0, 3'b110);
    repeat (4) @(negedge clk);
    selectOn();
    for (int k = 0; k < 4; k++) pulse(1'b0);
    selectOff();
    selectOn();
    sendOp(8'h05);
    streamByte(expStatus(), 1'b0, 1'b0, 3'b0);
    selectOff();
    check(expQ.size() == 0, "R11 read after abort", expQ.size(), 0);

    // R11 abort mid status byte then a clean read
    selectOn();
    sendOp(8'h05);
    capOn = 1'b0;
    for (int k = 0; k < 3; k++) pulse(1'b0);
    selectOff();
    selectOn();
    sendOp(8'h05);
    streamByte(expStatus(), 1'b0, 1'b0, 3'b0);
    selectOff();
    check(expQ.size() == 0, "R11 read after stream abort", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule